// File: doc/BRIEF.md
# Display Power Sequencer

This block drives the power sequencing of an external display controller through a register access master. After reset it reads the controller's identification register and accepts the controller only if the masked value matches. It then starts the controller's oscillator, waits, and leaves the controller's index register pointing at graphics RAM. From then on it turns the panel supply on or off on request, issuing an ordered list of register writes separated by millisecond waits.

Commands go to the register access master over a valid/ready channel. The sequencer holds a command, with its operation, address and data, stable while `cmd_valid` is high and `cmd_ready` is low. Only one command is outstanding at a time: after a command is accepted, the block waits for a one-cycle `rsp_valid` pulse before it issues anything else. Power requests are strobes carrying the wanted state. A strobe that arrives while the block is busy is held, with the latest one winning, and is acted on once the block is ready again. Wait lengths come from a cycle counter that is scaled by a clocks-per-millisecond parameter.

Top module: `disp_pwr_seq`

## Requirements
- R1: After reset `busy` is 1, `ready` is 0 and `pwr_on` is 0. The first command issued is a read (`cmd_op`=0) of address 0x00.
- R2: The identification value is accepted when `(rsp_rdata & 0xFFF0) == 0x9220`. Any other value, or an error response during start-up, sets `err_nodev` permanently. After that no further command is issued, `busy` and `ready` stay 0, and power requests are ignored.
- R3: After an accepted identification the block writes (`cmd_op`=1) 0x0001 to address 0x00, waits 10 ms, and then issues an index-only command (`cmd_op`=2) with address 0x22. It then raises `ready`.
- R4: A power-on request issues these writes in order: 0x10←0x0000, 0x11←0x0000, 0x12←0x0000, 0x13←0x0000, 0x56←0x080F, 0x10←0x4240, 0x11←0x0000, 0x12←0x0014, 0x13←0x1319. After they complete, `pwr_on` becomes 1.
- R5: A power-off request issues only the first four writes of R4, with their waits. After they complete, `pwr_on` becomes 0.
- R6: The waits are 10 ms after each write to 0x10, 40 ms after the first write to 0x12 of each half, and 40 ms after each write to 0x13. One millisecond is `CLKS_PER_MS` clock cycles.
- R7: A request for the state that `pwr_on` already shows issues no command and leaves `ready` at 1.
- R8: A request strobe that arrives while `busy` is 1 is held and serviced after the current sequence. Of several such strobes, the last one counts.
- R9: A response with `rsp_err`=1 during a power sequence ends that sequence at once. `pwr_on` is left unchanged and `err_seq` is set. `err_seq` clears when the next sequence starts.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, the command fields are held stable. No new command is issued until the response to the previous one has arrived.
- R11: At most one of `busy`, `ready` and `err_nodev` is 1 at any time, and `cmd_valid` is 0 whenever `ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_stb | input | 1 | Power request strobe |
| req_on | input | 1 | Requested state with the strobe: 1 on, 0 off |
| cmd_valid | output | 1 | Command offered to the register master |
| cmd_ready | input | 1 | Register master takes the command |
| cmd_op | output | 2 | 0 read, 1 index plus value write, 2 index only |
| cmd_addr | output | 8 | Register address |
| cmd_wdata | output | 16 | Value to write |
| rsp_valid | input | 1 | One-cycle pulse: the accepted command has finished |
| rsp_err | input | 1 | The finished command failed |
| rsp_rdata | input | 16 | Read data with the response |
| busy | output | 1 | Checking the controller or running a sequence |
| ready | output | 1 | Idle and able to run a sequence |
| err_nodev | output | 1 | Controller missing or wrong identification |
| err_seq | output | 1 | The last power sequence failed |
| pwr_on | output | 1 | Current panel power state |

## Verification
The bench builds the block with `CLKS_PER_MS` set to 20. This scales the longest power-on run (180 ms of waits) down to a few thousand cycles, so that every wait can be measured exactly against its expected cycle count in a short run. The stand-in register master stalls `cmd_ready` for zero to two cycles, so that the hold rules apply on real back-pressure. An identification value whose low nibble is all ones exercises the mask, and a second reset with a foreign value exercises the rejection path.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [1:0] {OP_READ = 2'd0, OP_WRITE = 2'd1, OP_INDEX = 2'd2, OP_WAIT = 2'd3} op_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  addr;
    logic [15:0] data;   // write value, or wait length in ms
  } step_t;

  localparam int STEP_W        = 5;
  localparam logic [4:0] ST_ID       = 5'd0;
  localparam logic [4:0] ST_INIT_END = 5'd3;
  localparam logic [4:0] ST_SEQ_BEG  = 5'd4;
  localparam logic [4:0] ST_OFF_END  = 5'd10;
  localparam logic [4:0] ST_ON_END   = 5'd18;

  localparam logic [15:0] ID_MASK  = 16'hFFF0;
  localparam logic [15:0] ID_MATCH = 16'h9220;
endpackage

// File: rtl/dps_step_rom.sv
module dps_step_rom
  import dps_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  always_comb begin
    step = '{op: OP_WAIT, addr: 8'h00, data: 16'd1};
    case (idx)
      5'd0:  step = '{op: OP_READ,  addr: 8'h00, data: 16'h0000};
      5'd1:  step = '{op: OP_WRITE, addr: 8'h00, data: 16'h0001};
      5'd2:  step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd10};
      5'd3:  step = '{op: OP_INDEX, addr: 8'h22, data: 16'h0000};
      5'd4:  step = '{op: OP_WRITE, addr: 8'h10, data: 16'h0000};
      5'd5:  step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd10};
      5'd6:  step = '{op: OP_WRITE, addr: 8'h11, data: 16'h0000};
      5'd7:  step = '{op: OP_WRITE, addr: 8'h12, data: 16'h0000};
      5'd8:  step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd40};
      5'd9:  step = '{op: OP_WRITE, addr: 8'h13, data: 16'h0000};
      5'd10: step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd40};
      5'd11: step = '{op: OP_WRITE, addr: 8'h56, data: 16'h080F};
      5'd12: step = '{op: OP_WRITE, addr: 8'h10, data: 16'h4240};
      5'd13: step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd10};
      5'd14: step = '{op: OP_WRITE, addr: 8'h11, data: 16'h0000};
      5'd15: step = '{op: OP_WRITE, addr: 8'h12, data: 16'h0014};
      5'd16: step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd40};
      5'd17: step = '{op: OP_WRITE, addr: 8'h13, data: 16'h1319};
      5'd18: step = '{op: OP_WAIT,  addr: 8'h00, data: 16'd40};
      default: step = '{op: OP_WAIT, addr: 8'h00, data: 16'd1};
    endcase
  end
endmodule

// File: rtl/dps_ms_timer.sv
module dps_ms_timer #(
  parameter int CLKS_PER_MS = 50000,
  parameter int MS_W        = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MS_W-1:0] ms,
  output logic            done
);
  localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam logic [CW-1:0] CYC_LAST = CW'(CLKS_PER_MS - 1);

  logic [CW-1:0]   cyc;
  logic [MS_W-1:0] left;
  logic            run;

  assign done = run && (cyc == CYC_LAST) && (left == MS_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc  <= '0;
      left <= '0;
      run  <= 1'b0;
    end else if (load) begin
      cyc  <= '0;
      left <= ms;
      run  <= (ms != '0);
    end else if (run) begin
      if (cyc == CYC_LAST) begin
        cyc  <= '0;
        left <= left - MS_W'(1);
        if (left == MS_W'(1)) run <= 1'b0;
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end
endmodule

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq
  import dps_pkg::*;
#(
  parameter int CLKS_PER_MS = 50000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_stb,
  input  logic        req_on,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_addr,
  output logic [15:0] cmd_wdata,
  input  logic        rsp_valid,
  input  logic        rsp_err,
  input  logic [15:0] rsp_rdata,
  output logic        busy,
  output logic        ready,
  output logic        err_nodev,
  output logic        err_seq,
  output logic        pwr_on
);
  typedef enum logic [2:0] {S_IDLE, S_STEP, S_CMD, S_RSP, S_WAIT, S_NODEV} state_e;
  typedef enum logic [1:0] {M_INIT, M_ON, M_OFF} mode_e;

  state_e            state;
  mode_e             mode;
  logic [STEP_W-1:0] step_idx, last_idx;
  logic              pend_v, pend_on, on_q, seq_err_q;
  step_t             cur;
  logic              tmr_load, tmr_done, id_ok, step_done;

  dps_step_rom u_rom (.idx(step_idx), .step(cur));

  dps_ms_timer #(.CLKS_PER_MS(CLKS_PER_MS), .MS_W(8)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .ms(cur.data[7:0]), .done(tmr_done)
  );

  assign tmr_load  = (state == S_STEP) && (cur.op == OP_WAIT);
  assign id_ok     = (step_idx != ST_ID) || ((rsp_rdata & ID_MASK) == ID_MATCH);
  assign step_done = ((state == S_RSP) && rsp_valid && !rsp_err && id_ok) ||
                     ((state == S_WAIT) && tmr_done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_STEP;
      mode      <= M_INIT;
      step_idx  <= ST_ID;
      last_idx  <= ST_INIT_END;
      pend_v    <= 1'b0;
      pend_on   <= 1'b0;
      on_q      <= 1'b0;
      seq_err_q <= 1'b0;
    end else begin
      if (req_stb) begin
        pend_v  <= 1'b1;
        pend_on <= req_on;
      end
      case (state)
        S_IDLE: begin
          if (pend_v) begin
            if (!req_stb) pend_v <= 1'b0;
            if (pend_on != on_q) begin
              mode      <= pend_on ? M_ON : M_OFF;
              step_idx  <= ST_SEQ_BEG;
              last_idx  <= pend_on ? ST_ON_END : ST_OFF_END;
              seq_err_q <= 1'b0;
              state     <= S_STEP;
            end
          end
        end
        S_STEP: state <= (cur.op == OP_WAIT) ? S_WAIT : S_CMD;
        S_CMD:  if (cmd_ready) state <= S_RSP;
        S_RSP: begin
          if (rsp_valid && rsp_err) begin
            if (mode == M_INIT) state <= S_NODEV;
            else begin
              seq_err_q <= 1'b1;
              state     <= S_IDLE;
            end
          end else if (rsp_valid && !id_ok) begin
            state <= S_NODEV;
          end
        end
        S_NODEV: pend_v <= 1'b0;
        default: ;
      endcase
      if (step_done) begin
        if (step_idx == last_idx) begin
          state <= S_IDLE;
          if (mode == M_ON)       on_q <= 1'b1;
          else if (mode == M_OFF) on_q <= 1'b0;
        end else begin
          step_idx <= step_idx + STEP_W'(1);
          state    <= S_STEP;
        end
      end
    end
  end

  assign cmd_valid = (state == S_CMD);
  assign cmd_op    = cur.op;
  assign cmd_addr  = cur.addr;
  assign cmd_wdata = cur.data;
  assign busy      = (state != S_IDLE) && (state != S_NODEV);
  assign ready     = (state == S_IDLE);
  assign err_nodev = (state == S_NODEV);
  assign err_seq   = seq_err_q;
  assign pwr_on    = on_q;
endmodule

// File: rtl/disp_pwr_seq_chk.sv
module disp_pwr_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [1:0]  cmd_op,
  input logic [7:0]  cmd_addr,
  input logic [15:0] cmd_wdata,
  input logic        rsp_valid,
  input logic        busy,
  input logic        ready,
  input logic        err_nodev,
  input logic        pwr_on
);
  logic outstanding;
  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (cmd_valid && cmd_ready) outstanding <= 1'b1;
    else if (rsp_valid) outstanding <= 1'b0;
  end

  // R10: command held under back-pressure
  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_wdata));
  // R10: one command outstanding
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !cmd_valid);
  // R11
  p_status_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, ready, err_nodev}));
  p_no_cmd_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !cmd_valid);
  // R2
  p_nodev_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_nodev |=> err_nodev && !cmd_valid);
  // R4/R5: power state only moves at the end of a sequence
  p_pwr_change_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_on) |-> ready);
endmodule

bind disp_pwr_seq disp_pwr_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .busy(busy), .ready(ready), .err_nodev(err_nodev), .pwr_on(pwr_on)
);

// File: tb/disp_pwr_seq_tb.sv
`timescale 1ns/1ps
module disp_pwr_seq_tb;
  localparam int C = 20;

  logic clk = 0, rst_n = 0, req_stb = 0, req_on = 0;
  logic cmd_valid, cmd_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic [1:0] cmd_op;
  logic [7:0] cmd_addr;
  logic [15:0] cmd_wdata, rsp_rdata = 0;
  logic busy, ready, err_nodev, err_seq, pwr_on;

  int checks = 0, errors = 0, cyc = 0;
  int n_log = 0, err_at = -1;
  logic [15:0] id_val = 16'h922F;
  logic [1:0]  l_op [64];
  logic [7:0]  l_addr [64];
  logic [15:0] l_data [64];
  int          l_cyc [64];

  disp_pwr_seq #(.CLKS_PER_MS(C)) u_dut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // register master stand-in
  initial begin
    int stall_cnt;
    stall_cnt = 0;
    forever begin
      @(negedge clk);
      rsp_valid = 0; rsp_err = 0; cmd_ready = 0;
      if (cmd_valid && rst_n) begin
        if (stall_cnt >= (n_log % 3)) begin
          stall_cnt = 0;
          if (n_log < 64) begin
            l_op[n_log] = cmd_op; l_addr[n_log] = cmd_addr;
            l_data[n_log] = cmd_wdata; l_cyc[n_log] = cyc;
          end
          cmd_ready = 1;
          @(negedge clk);
          cmd_ready = 0;
          @(negedge clk);
          rsp_valid = 1;
          rsp_rdata = (l_op[n_log] == 2'd0) ? id_val : 16'h0;
          rsp_err = (n_log == err_at);
          n_log++;
        end else stall_cnt++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (ready) break;
    end
  endtask

  task automatic request(input logic on);
    @(negedge clk); req_stb = 1; req_on = on;
    @(negedge clk); req_stb = 0;
  endtask

  task automatic do_reset(input logic [15:0] id);
    id_val = id;
    @(negedge clk); rst_n = 0;
    repeat (4) @(negedge clk);
    n_log = 0;
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic chk_gap(input string req, input int a, input int ms);
    int g;
    g = l_cyc[a+1] - l_cyc[a];
    checks++;
    if (g < ms * C || g > ms * C + 10) begin
      errors++;
      $display("FAIL %s gap after cmd %0d: actual %0d expected %0d..%0d", req, a, g, ms*C, ms*C+10);
    end
  endtask

  task automatic chk_on_list(input int base);
    logic [7:0]  ea [9] = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h56, 8'h10, 8'h11, 8'h12, 8'h13};
    logic [15:0] ed [9] = '{16'h0, 16'h0, 16'h0, 16'h0, 16'h080F, 16'h4240, 16'h0, 16'h0014, 16'h1319};
    for (int i = 0; i < 9; i++) begin
      chk("R4", "on addr", l_addr[base+i], ea[i]);
      chk("R4", "on data", l_data[base+i], ed[i]);
      chk("R4", "on op", l_op[base+i], 1);
    end
  endtask

  task automatic t_reset_init();
    @(negedge clk);
    chk("R1", "busy after reset", busy, 1);
    chk("R1", "ready after reset", ready, 0);
    chk("R1", "pwr_on after reset", pwr_on, 0);
    wait_ready();
    chk("R1", "first op read", l_op[0], 0);
    chk("R1", "first addr", l_addr[0], 8'h00);
    chk("R2", "masked id accepted", err_nodev, 0);
    chk("R3", "osc write addr", l_addr[1], 8'h00);
    chk("R3", "osc write data", l_data[1], 16'h0001);
    chk("R3", "index op", l_op[2], 2);
    chk("R3", "index addr", l_addr[2], 8'h22);
    chk("R3", "cmd count", n_log, 3);
    chk_gap("R6", 1, 10);
  endtask

  task automatic t_power_on();
    n_log = 0;
    request(1);
    @(negedge clk);
    chk("R11", "busy in seq", busy, 1);
    chk("R11", "ready low in seq", ready, 0);
    wait_ready();
    chk("R10", "one accept per command", n_log, 9);
    chk_on_list(0);
    chk("R4", "pwr_on set", pwr_on, 1);
    chk_gap("R6", 0, 10);
    chk_gap("R6", 2, 40);
    chk_gap("R6", 3, 40);
    chk_gap("R6", 5, 10);
    chk_gap("R6", 7, 40);
  endtask

  task automatic t_same_state();
    n_log = 0;
    request(1);
    repeat (50) @(negedge clk);
    chk("R7", "no command", n_log, 0);
    chk("R7", "still ready", ready, 1);
    chk("R7", "still on", pwr_on, 1);
  endtask

  task automatic t_power_off();
    logic [7:0] ea [4] = '{8'h10, 8'h11, 8'h12, 8'h13};
    n_log = 0;
    request(0);
    repeat (3) @(negedge clk);
    wait_ready();
    chk("R5", "off count", n_log, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R5", "off addr", l_addr[i], ea[i]);
      chk("R5", "off data", l_data[i], 0);
    end
    chk("R5", "pwr_on cleared", pwr_on, 0);
    chk_gap("R6", 2, 40);
  endtask

  task automatic t_latch();
    n_log = 0;
    request(1);
    repeat (30) @(negedge clk);
    request(1);
    request(0);
    repeat (3) @(negedge clk);
    wait_ready();
    repeat (3) @(negedge clk);
    wait_ready();
    chk("R8", "on then off count", n_log, 13);
    chk_on_list(0);
    chk("R8", "off after on addr", l_addr[9], 8'h10);
    chk("R8", "final state off", pwr_on, 0);
  endtask

  task automatic t_err();
    n_log = 0; err_at = 2;
    request(1);
    repeat (3) @(negedge clk);
    wait_ready();
    chk("R9", "aborted count", n_log, 3);
    chk("R9", "state kept", pwr_on, 0);
    chk("R9", "err_seq set", err_seq, 1);
    err_at = -1; n_log = 0;
    request(1);
    repeat (3) @(negedge clk);
    chk("R9", "err_seq cleared", err_seq, 0);
    wait_ready();
    chk("R9", "retry on", pwr_on, 1);
  endtask

  task automatic t_nodev();
    do_reset(16'h9310);
    repeat (20) @(negedge clk);
    chk("R2", "nodev flag", err_nodev, 1);
    chk("R2", "busy low", busy, 0);
    chk("R2", "ready low", ready, 0);
    request(1);
    repeat (40) @(negedge clk);
    chk("R2", "no commands after reject", n_log, 1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    t_reset_init();
    t_power_on();
    t_same_state();
    t_power_off();
    t_latch();
    t_err();
    t_nodev();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule